// File: doc/BRIEF.md
# Per-CPU Device Interrupt Mask Unit

This block holds one raw vector of pending device interrupt requests that all processors share, and a separate enable mask for every processor. For each processor it keeps a directed vector, which is that processor's mask ANDed with the raw vector. It also drives one level interrupt line per processor, which stays high while that processor's directed vector has any bit set. Device sources post and clear their requests through two indexed event ports. Software programs the masks through a 64-bit register port.

The register port decodes a large address window. One offset bit selects an array of mask registers and another selects an array of directed-vector registers. In both arrays a six-bit field of the offset picks the processor. Outside the window the offset is divided into 64-byte register slots. The first four slots are a second way to reach the masks of processors 0 to 3. Every state change takes effect at the clock edge that samples the event. The interrupt lines are registered, so they follow at that same edge.

Top module: `devint_mask_unit`

## Requirements
- R1: After synchronous reset the raw vector, every mask, every directed vector and every interrupt line are zero.
- R2: A post event with index n sets raw bit n at the next clock edge. Posting a bit that is already set leaves it set.
- R3: A clear event with index n clears raw bit n at the next clock edge. When a post and a clear name the same index in one cycle, the post wins and the bit ends set.
- R4: At every edge each processor's directed vector equals its mask ANDed with the raw vector. It updates at the same edge as the operand that changed.
- R5: Processor c's interrupt line is high exactly while its directed vector is nonzero. It rises or falls at the same edge as the directed vector.
- R6: An access with offset bit 24 set reaches the mask array, and offset bits 9:4 give the processor index. A write replaces the whole 64-bit mask. Bit 24 takes priority when bit 25 is also set.
- R7: An access with offset bit 25 set and bit 24 clear reads the directed-vector array, indexed by bits 9:4. A write there changes no mask, no directed vector and no line.
- R8: Outside the window, the slot number is the offset shifted right by 6. Slots 0 to 3 read and write the masks of processors 0 to 3. All other slots read as zero and ignore writes.
- R9: Read data appears with reg_rvalid one cycle after reg_rd. It shows the state from before any update that lands in the same cycle.
- R10: A processor index at or above NUM_CPUS reads as zero, and a write to it changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_post | input | 1 | Device request post strobe |
| dev_post_idx | input | IDX_W | Source index to post |
| dev_clr | input | 1 | Device request clear strobe |
| dev_clr_idx | input | IDX_W | Source index to clear |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset inside the block |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, registered |
| reg_rvalid | output | 1 | Read data valid |
| irq_dev | output | NUM_CPUS | Per-processor device interrupt level |

## Verification
Two things can land in the same cycle: a device event that changes the raw vector, and a mask write to a processor. The directed vector must then be built from both new operands. The bench provokes this on purpose. In one cycle it posts a source while writing a mask that enables only that source, and in another it clears a source while the mask that covered it is rewritten. The random phase also mixes events and writes freely in single cycles. Each result is judged against a bench model that applies the clear, then the post, then the mask write, and checks every processor's line and the read-back directed vector. A read issued in the same cycle must still return the value from before the update.

// File: rtl/devint_pkg.sv
package devint_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_DIR  = 2'd2
  } reg_sel_e;

  localparam int CPU_FIELD_W = 6;
  localparam int WIN_MASK_BIT = 24;
  localparam int WIN_DIR_BIT  = 25;
  localparam int SLOT_SHIFT   = 6;
  localparam int ALIAS_SLOTS  = 4;
endpackage

// File: rtl/devint_reg_decode.sv
module devint_reg_decode
  import devint_pkg::*;
#(
  parameter int ADDR_W   = 28,
  parameter int NUM_CPUS = 8
) (
  input  logic [ADDR_W-1:0]      addr,
  output reg_sel_e               sel,
  output logic [CPU_FIELD_W-1:0] cpu_idx,
  output logic                   cpu_ok
);
  localparam int SLOT_W = ADDR_W - SLOT_SHIFT;

  logic [SLOT_W-1:0] slot;
  assign slot = addr[ADDR_W-1:SLOT_SHIFT];

  always_comb begin
    sel     = SEL_NONE;
    cpu_idx = '0;
    if (addr[WIN_MASK_BIT]) begin
      sel     = SEL_MASK;
      cpu_idx = addr[4 +: CPU_FIELD_W];
    end else if (addr[WIN_DIR_BIT]) begin
      sel     = SEL_DIR;
      cpu_idx = addr[4 +: CPU_FIELD_W];
    end else if (slot < SLOT_W'(ALIAS_SLOTS)) begin
      sel     = SEL_MASK;
      cpu_idx = slot[CPU_FIELD_W-1:0];
    end
  end

  assign cpu_ok = (32'(cpu_idx) < 32'(NUM_CPUS));
endmodule

// File: rtl/devint_raw_vec.sv
module devint_raw_vec #(
  parameter int NUM_SRC = 64,
  localparam int IDX_W = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               post,
  input  logic [IDX_W-1:0]   post_idx,
  input  logic               clr,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [NUM_SRC-1:0] raw_q,
  output logic [NUM_SRC-1:0] raw_nxt
);
  logic [NUM_SRC-1:0] set_bits, drop_bits;

  assign set_bits  = post ? (NUM_SRC'(1) << post_idx) : '0;
  assign drop_bits = clr  ? (NUM_SRC'(1) << clr_idx)  : '0;
  // clear first, then post: post wins on a shared index
  assign raw_nxt   = (raw_q & ~drop_bits) | set_bits;

  always_ff @(posedge clk) begin
    if (rst) raw_q <= '0;
    else     raw_q <= raw_nxt;
  end

  p_post_sets_r2: assert property (@(posedge clk) disable iff (rst)
    post |=> raw_q[$past(post_idx)]);

  p_clr_drops_r3: assert property (@(posedge clk) disable iff (rst)
    (clr && !(post && post_idx == clr_idx)) |=> !raw_q[$past(clr_idx)]);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!post && !clr) |=> $stable(raw_q));
endmodule

// File: rtl/devint_cpu_slice.sv
module devint_cpu_slice #(
  parameter int NUM_SRC = 64
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wdata,
  input  logic [NUM_SRC-1:0] raw_q,
  input  logic [NUM_SRC-1:0] raw_nxt,
  output logic [NUM_SRC-1:0] mask_q,
  output logic [NUM_SRC-1:0] dir_q,
  output logic               irq_q
);
  logic [NUM_SRC-1:0] mask_nxt, dir_nxt;

  assign mask_nxt = wr_en ? wdata : mask_q;
  assign dir_nxt  = mask_nxt & raw_nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      dir_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      mask_q <= mask_nxt;
      dir_q  <= dir_nxt;
      irq_q  <= |dir_nxt;
    end
  end

  p_dir_and_r4: assert property (@(posedge clk) disable iff (rst)
    dir_q == (mask_q & raw_q));

  p_irq_level_r5: assert property (@(posedge clk) disable iff (rst)
    irq_q == (dir_q != '0));

  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mask_q));

  p_mask_load_r6: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> mask_q == $past(wdata));
endmodule

// File: rtl/devint_mask_unit.sv
module devint_mask_unit
  import devint_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int NUM_SRC  = 64,
  parameter int ADDR_W   = 28,
  localparam int IDX_W   = $clog2(NUM_SRC),
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dev_post,
  input  logic [IDX_W-1:0]    dev_post_idx,
  input  logic                dev_clr,
  input  logic [IDX_W-1:0]    dev_clr_idx,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [63:0]         reg_wdata,
  output logic [63:0]         reg_rdata,
  output logic                reg_rvalid,
  output logic [NUM_CPUS-1:0] irq_dev
);
  reg_sel_e               sel;
  logic [CPU_FIELD_W-1:0] cpu_idx;
  logic                   cpu_ok;
  logic [NUM_SRC-1:0]     raw_q, raw_nxt;
  logic [NUM_SRC-1:0]     mask_arr [NUM_CPUS];
  logic [NUM_SRC-1:0]     dir_arr  [NUM_CPUS];
  logic [NUM_CPUS*NUM_SRC-1:0] mask_flat, dir_flat;
  logic [CPU_W-1:0]       sel_cpu;

  devint_reg_decode #(.ADDR_W(ADDR_W), .NUM_CPUS(NUM_CPUS)) u_dec (
    .addr(reg_addr), .sel(sel), .cpu_idx(cpu_idx), .cpu_ok(cpu_ok)
  );

  devint_raw_vec #(.NUM_SRC(NUM_SRC)) u_raw (
    .clk(clk), .rst(rst),
    .post(dev_post), .post_idx(dev_post_idx),
    .clr(dev_clr), .clr_idx(dev_clr_idx),
    .raw_q(raw_q), .raw_nxt(raw_nxt)
  );

  assign sel_cpu = cpu_idx[CPU_W-1:0];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    logic wr_hit;
    assign wr_hit = reg_wr && (sel == SEL_MASK) && cpu_ok &&
                    (32'(cpu_idx) == c);
    devint_cpu_slice #(.NUM_SRC(NUM_SRC)) u_slice (
      .clk(clk), .rst(rst),
      .wr_en(wr_hit), .wdata(reg_wdata[NUM_SRC-1:0]),
      .raw_q(raw_q), .raw_nxt(raw_nxt),
      .mask_q(mask_arr[c]), .dir_q(dir_arr[c]), .irq_q(irq_dev[c])
    );
    assign mask_flat[c*NUM_SRC +: NUM_SRC] = mask_arr[c];
    assign dir_flat[c*NUM_SRC +: NUM_SRC]  = dir_arr[c];
  end

  logic [63:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (cpu_ok) begin
      unique case (sel)
        SEL_MASK: rd_mux = 64'(mask_arr[sel_cpu]);
        SEL_DIR:  rd_mux = 64'(dir_arr[sel_cpu]);
        default:  rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      reg_rdata  <= reg_rd ? rd_mux : '0;
    end
  end

  p_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
    reg_rd |=> reg_rvalid);

  p_no_rvalid_r9: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> !reg_rvalid);

  p_dir_write_inert_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr[WIN_DIR_BIT] && !reg_addr[WIN_MASK_BIT])
      |=> $stable(mask_flat));

  p_bad_cpu_inert_r10: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && !cpu_ok) |=> $stable(mask_flat));

  p_dir_follows_r4: assert property (@(posedge clk) disable iff (rst)
    (!reg_wr && !dev_post && !dev_clr) |=> $stable(dir_flat));
endmodule

// File: tb/devint_mask_unit_bench.sv
module devint_mask_unit_bench;
  localparam int N = 8;
  localparam int AW = 28;

  logic clk = 0, rst = 1;
  logic dev_post = 0, dev_clr = 0, reg_wr = 0, reg_rd = 0;
  logic [5:0] dev_post_idx = 0, dev_clr_idx = 0;
  logic [AW-1:0] reg_addr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  logic reg_rvalid;
  logic [N-1:0] irq_dev;

  always #5 clk = ~clk;

  devint_mask_unit #(.NUM_CPUS(N), .NUM_SRC(64), .ADDR_W(AW)) u_devint_mask_unit (
    .clk(clk), .rst(rst), .dev_post(dev_post), .dev_post_idx(dev_post_idx),
    .dev_clr(dev_clr), .dev_clr_idx(dev_clr_idx), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .irq_dev(irq_dev)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] m_raw;
  logic [63:0] m_mask [N];

  function automatic logic [AW-1:0] a_mask(int c); return AW'(32'h0100_0000 | (c << 4)); endfunction
  function automatic logic [AW-1:0] a_dir(int c);  return AW'(32'h0200_0000 | (c << 4)); endfunction
  function automatic logic [AW-1:0] a_slot(int s); return AW'(s << 6); endfunction

  function automatic logic [63:0] exp_read(logic [AW-1:0] a);
    int c, s;
    if (a[24]) begin c = int'(a[9:4]); return (c < N) ? m_mask[c] : 64'd0; end
    if (a[25]) begin c = int'(a[9:4]); return (c < N) ? (m_mask[c] & m_raw) : 64'd0; end
    s = int'(a[AW-1:6]);
    return (s < 4 && s < N) ? m_mask[s] : 64'd0;
  endfunction

  task automatic model_write(logic [AW-1:0] a, logic [63:0] d);
    int c, s;
    if (a[24]) begin c = int'(a[9:4]); if (c < N) m_mask[c] = d; end
    else if (!a[25]) begin s = int'(a[AW-1:6]); if (s < 4 && s < N) m_mask[s] = d; end
  endtask

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_irq(string req);
    logic [N-1:0] e;
    for (int c = 0; c < N; c++) e[c] = |(m_mask[c] & m_raw);
    chk(irq_dev == e, req, 64'(irq_dev), 64'(e));
  endtask

  // one cycle: any mix of post, clear, write, read
  task automatic op(bit p, int pi, bit cl, int ci, bit w, bit r,
                    logic [AW-1:0] a, logic [63:0] d, string req);
    logic [63:0] er;
    @(negedge clk);
    dev_post = p; dev_post_idx = 6'(pi); dev_clr = cl; dev_clr_idx = 6'(ci);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
    er = exp_read(a);
    @(posedge clk); #1;
    dev_post = 0; dev_clr = 0; reg_wr = 0; reg_rd = 0;
    if (cl) m_raw[ci] = 1'b0;
    if (p)  m_raw[pi] = 1'b1;
    if (w)  model_write(a, d);
    @(negedge clk);
    if (r) begin
      chk(reg_rvalid === 1'b1, {req, " rvalid R9"}, 64'(reg_rvalid), 64'd1);
      chk(reg_rdata === er, {req, " rdata"}, reg_rdata, er);
    end
    check_irq({req, " irq R5"});
  endtask

  task automatic rd(logic [AW-1:0] a, string req);
    op(0, 0, 0, 0, 0, 1, a, 0, req);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_raw = '0;
    for (int c = 0; c < N; c++) m_mask[c] = '0;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(irq_dev == '0, "R1 irq", 64'(irq_dev), 0);
    chk(reg_rvalid == 0, "R1 rvalid", 64'(reg_rvalid), 0);
    rd(a_mask(0), "R1 mask0");
    rd(a_dir(N-1), "R1 dir");
    // R2 post with no mask: no line
    op(1, 5, 0, 0, 0, 0, 0, 0, "R2 post5");
    rd(a_dir(0), "R4 dir0 zero");
    // R6 mask window write, line rises (R5)
    op(0, 0, 0, 0, 1, 0, a_mask(0), 64'h20, "R6 mask0");
    rd(a_dir(0), "R4 dir0");
    // R6 bit24 priority over bit25
    op(0, 0, 0, 0, 1, 1, AW'(32'h0300_0010), 64'h0F, "R6 both bits");
    rd(a_mask(1), "R6 mask1");
    // R8 alias slot 2, then unmapped slot 5
    op(0, 0, 0, 0, 1, 0, a_slot(2), 64'h8000_0000_0000_0020, "R8 alias2");
    rd(a_mask(2), "R8 alias readback");
    op(0, 0, 0, 0, 1, 1, a_slot(5), 64'hFFFF, "R8 slot5");
    rd(a_slot(3), "R8 alias3");
    // R7 write to directed array ignored
    op(0, 0, 0, 0, 1, 0, a_dir(0), 64'hFFFF_FFFF_FFFF_FFFF, "R7 dir write");
    rd(a_mask(0), "R7 mask0 kept");
    rd(a_dir(0), "R7 dir0 kept");
    // R10 out-of-range cpu
    op(0, 0, 0, 0, 1, 1, a_mask(12), 64'hFF, "R10 cpu12");
    rd(a_mask(12), "R10 read");
    // R3 post+clear same index: post wins
    op(1, 63, 1, 63, 0, 0, 0, 0, "R3 same idx");
    rd(a_dir(2), "R3 dir2");
    // R3 clear drops line
    op(0, 0, 1, 5, 0, 0, 0, 0, "R3 clr5");
    // R4 same-cycle post and mask write, read sees old state (R9)
    op(1, 9, 0, 0, 1, 1, a_mask(3), 64'h200, "R4 post+write");
    rd(a_dir(3), "R4 dir3");
    // R4 clear while covering mask rewritten
    op(0, 0, 1, 9, 1, 1, a_mask(3), 64'h201, "R4 clr+write");
    op(0, 0, 1, 40, 0, 0, 0, 0, "R3 clr unset");
    // random mix
    for (int i = 0; i < 400; i++) begin
      bit p, cl, w, r;
      int k;
      logic [AW-1:0] a;
      p = ($urandom % 3) == 0; cl = ($urandom % 3) == 0;
      w = ($urandom % 3) == 0; r = ($urandom % 2) == 0;
      k = $urandom % 4;
      case (k)
        0: a = a_mask($urandom % 10);
        1: a = a_dir($urandom % 10);
        2: a = a_slot($urandom % 7);
        default: a = AW'($urandom);
      endcase
      op(p, $urandom % 64, cl, $urandom % 64, w, r, a,
         {$urandom, $urandom} & ((i % 2) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_00FF_00FF),
         "R4 random");
    end
    for (int c = 0; c < N; c++) rd(a_dir(c), "R4 final dir");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule